// File: doc/BRIEF.md
# Polled Bus Client Transmitter

This block is the client end of a shared bus that a single master controls by polling. It watches decoded frames on the bus and keeps only those whose destination field matches its own address. A query addressed to it is answered at once. The answer is itself the acknowledgement, and it says whether the local payload source holds any frames. If the client said it has data, it waits a bounded time for a grant. It acknowledges the grant and then has the bus to itself.

While it holds the bus, the client sends one data frame at a time. After each frame it waits for an acknowledgement before it moves on. An unanswered frame is sent again up to twice. After the third silent wait the frame is dropped, and a failure counter advances. The grant ends in one of two ways. Either the source runs dry and the client sends an end frame, or a grant window measured in ticks runs out and the client falls silent at once. Frame serialisation and the line itself sit outside the block. The transmitter takes one frame kind per handshake, and the payload source is popped once per frame that is finished.

Top module: `poll_client_tx`

## Requirements
- R1: A received frame whose destination differs from `my_addr` has no effect: a query to another address draws no reply, and an acknowledgement to another address does not stop a retransmission.
- R2: While idle, grant frames (kind 2) and acknowledgement frames (kind 3) are ignored, and the block requests no transmission after reset.
- R3: A local query (receive kind 1) is answered with kind 5 when `pend_avail` is high and kind 4 when it is low; after kind 4 the block is idle again.
- R4: After a kind 5 reply, a local grant (kind 2) received within `ACK_TICKS` ticks is acknowledged with a kind 3 frame; if the wait expires first, the block returns to idle and a later grant is ignored.
- R5: Each data frame (kind 6) is followed by a wait; no further frame goes out until a local acknowledgement (kind 3) arrives, which pops the source with a one-cycle `pend_take` pulse.
- R6: An unacknowledged data frame is retransmitted at most twice; when the third wait of `ACK_TICKS` ticks expires, the frame is popped, `fail_count` increases by one, and the next pending frame is taken.
- R7: When `pend_avail` is low at the point of choosing the next frame, an end frame (kind 7) is sent and the block returns to idle.
- R8: When `GRANT_TICKS` ticks have passed since the grant, the block returns to idle at once, without an end frame.
- R9: While `tx_req` is high and `tx_ready` is low, `tx_req` stays high and `tx_kind` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time base enable for both timeout counters |
| my_addr | input | AW | Local station address |
| rx_valid | input | 1 | Decoded frame present this cycle |
| rx_dst | input | AW | Destination address of the received frame |
| rx_kind | input | 3 | Received kind: 1 query, 2 grant, 3 acknowledgement |
| tx_req | output | 1 | Frame waiting to be sent |
| tx_kind | output | 3 | Kind to send: 3 ack, 4 no data, 5 data pending, 6 data, 7 end |
| tx_ready | input | 1 | Transmitter accepts the frame when high with `tx_req` |
| pend_avail | input | 1 | Local source holds at least one frame |
| pend_take | output | 1 | One-cycle pop of the current source frame |
| fail_count | output | FW | Number of abandoned frames |

## Verification
The hardest situation to reach is the grant window running out while a frame sits between retransmissions. That needs a long source and an acknowledger that never answers, so the window and the retry schedule overlap. The stimulus loads ten frames, grants the bus and then stays silent. With one tick per cycle, two frames are abandoned before the window closes in the middle of the third. The bench then checks the failure count, the absence of an end frame and a quiet request line.

// File: rtl/poll_client_tx.sv
module poll_client_tx #(
  parameter int AW          = 6,
  parameter int ACK_TICKS   = 8,
  parameter int GRANT_TICKS = 64,
  parameter int MAX_RETRY   = 2,
  parameter int FW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [AW-1:0] my_addr,
  input  logic          rx_valid,
  input  logic [AW-1:0] rx_dst,
  input  logic [2:0]    rx_kind,
  output logic          tx_req,
  output logic [2:0]    tx_kind,
  input  logic          tx_ready,
  input  logic          pend_avail,
  output logic          pend_take,
  output logic [FW-1:0] fail_count
);
  localparam int WCW = $clog2(ACK_TICKS + 1);
  localparam int GCW = $clog2(GRANT_TICKS + 1);
  localparam int RCW = $clog2(MAX_RETRY + 1);

  localparam logic [2:0] RX_QUERY = 3'd1;
  localparam logic [2:0] RX_GRANT = 3'd2;
  localparam logic [2:0] RX_ACK   = 3'd3;
  localparam logic [2:0] TX_ACK   = 3'd3;
  localparam logic [2:0] TX_NONE  = 3'd4;
  localparam logic [2:0] TX_HAVE  = 3'd5;
  localparam logic [2:0] TX_DATA  = 3'd6;
  localparam logic [2:0] TX_END   = 3'd7;

  typedef enum logic [3:0] {
    S_IDLE, S_REPLY, S_WGRANT, S_GACK, S_NEXT, S_DATA, S_WACK, S_POP, S_END
  } st_t;

  st_t            st, nst;
  logic           has, has_n;
  logic [RCW-1:0] retry, retry_n;
  logic [WCW-1:0] wcnt;
  logic [GCW-1:0] gcnt;
  logic           fail_inc;

  wire hit     = rx_valid && (rx_dst == my_addr);
  wire sent    = tx_req && tx_ready;
  wire wait_to = tick && (wcnt == WCW'(ACK_TICKS - 1));
  wire granted = (st == S_GACK) || (st == S_NEXT) || (st == S_DATA) ||
                 (st == S_WACK) || (st == S_POP) || (st == S_END);
  wire win_to  = granted && tick && (gcnt == GCW'(GRANT_TICKS - 1));
  wire n_grant = (nst == S_GACK) || (nst == S_NEXT) || (nst == S_DATA) ||
                 (nst == S_WACK) || (nst == S_POP) || (nst == S_END);
  wire waiting = (st == S_WGRANT) || (st == S_WACK);

  assign tx_req    = (st == S_REPLY) || (st == S_GACK) || (st == S_DATA) || (st == S_END);
  assign pend_take = (st == S_POP);

  always_comb begin
    case (st)
      S_REPLY: tx_kind = has ? TX_HAVE : TX_NONE;
      S_GACK:  tx_kind = TX_ACK;
      S_DATA:  tx_kind = TX_DATA;
      S_END:   tx_kind = TX_END;
      default: tx_kind = 3'd0;
    endcase
  end

  always_comb begin
    nst      = st;
    has_n    = has;
    retry_n  = retry;
    fail_inc = 1'b0;
    case (st)
      S_IDLE:   if (hit && rx_kind == RX_QUERY) begin
                  nst   = S_REPLY;
                  has_n = pend_avail;
                end
      S_REPLY:  if (sent) nst = has ? S_WGRANT : S_IDLE;
      S_WGRANT: if (hit && rx_kind == RX_GRANT) nst = S_GACK;
                else if (wait_to) nst = S_IDLE;
      S_GACK:   if (sent) nst = S_NEXT;
      S_NEXT:   nst = pend_avail ? S_DATA : S_END;
      S_DATA:   if (sent) nst = S_WACK;
      S_WACK:   if (hit && rx_kind == RX_ACK) begin
                  nst     = S_POP;
                  retry_n = '0;
                end else if (wait_to) begin
                  if (retry == RCW'(MAX_RETRY)) begin
                    nst      = S_POP;
                    retry_n  = '0;
                    fail_inc = 1'b1;
                  end else begin
                    nst     = S_DATA;
                    retry_n = retry + 1'b1;
                  end
                end
      S_POP:    nst = S_NEXT;
      S_END:    if (sent) nst = S_IDLE;
      default:  nst = S_IDLE;
    endcase
    if (win_to) begin
      nst      = S_IDLE;
      retry_n  = '0;
      fail_inc = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      has        <= 1'b0;
      retry      <= '0;
      wcnt       <= '0;
      gcnt       <= '0;
      fail_count <= '0;
    end else begin
      st    <= nst;
      has   <= has_n;
      retry <= retry_n;
      if (!waiting || nst != st) wcnt <= '0;
      else if (tick)             wcnt <= wcnt + 1'b1;
      if (!n_grant)              gcnt <= '0;
      else if (granted && tick)  gcnt <= gcnt + 1'b1;
      if (fail_inc) fail_count <= fail_count + 1'b1;
    end
  end

  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && rx_valid && rx_dst != my_addr) |=> !tx_req); // R1
  AST_POP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_take |=> !pend_take); // R5
  AST_FAIL_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_count != $past(fail_count)) |-> (pend_take && fail_count == $past(fail_count) + 1'b1)); // R6
  AST_HOLD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_ready) |=> (tx_req && $stable(tx_kind))); // R9
endmodule

// File: tb/sim_poll_client_tx.sv
module sim_poll_client_tx;
  localparam logic [5:0] MINE  = 6'd5;
  localparam logic [5:0] OTHER = 6'd9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [5:0] rx_dst = '0;
  logic [2:0] rx_kind = '0;
  logic       tx_ready = 1'b1;
  logic       tx_req, pend_take;
  logic [2:0] tx_kind;
  logic [7:0] fail_count;
  int         pend_load = 0;
  int         pops = 0;
  int         log_n = 0;
  logic [2:0] log_k [0:63];
  int         n_run = 0;
  int         n_bad = 0;

  wire pend_avail = pend_load > pops;

  always #4 clk = ~clk;

  poll_client_tx u0 (
    .clk(clk), .rst_n(rst_n), .tick(1'b1), .my_addr(MINE),
    .rx_valid(rx_valid), .rx_dst(rx_dst), .rx_kind(rx_kind),
    .tx_req(tx_req), .tx_kind(tx_kind), .tx_ready(tx_ready),
    .pend_avail(pend_avail), .pend_take(pend_take), .fail_count(fail_count)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      log_n <= 0;
      pops  <= 0;
    end else begin
      if (tx_req && tx_ready && log_n < 64) begin
        log_k[log_n] <= tx_kind;
        log_n <= log_n + 1;
      end
      if (pend_take) pops <= pops + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart(input int n);
    @(negedge clk);
    rst_n = 1'b0;
    pend_load = n;
    tx_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rx(input logic [5:0] d, input logic [2:0] k);
    @(negedge clk);
    rx_valid = 1'b1; rx_dst = d; rx_kind = k;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic wait_log(input int n);
    for (int i = 0; i < 400 && log_n < n; i++) @(negedge clk);
  endtask

  // {mine, rx kind, pending, expected tx kind (0 = none)}
  localparam logic [7:0] VEC [0:6] = '{
    {1'b1, 3'd1, 1'b0, 3'd4},
    {1'b1, 3'd1, 1'b1, 3'd5},
    {1'b0, 3'd1, 1'b1, 3'd0},
    {1'b0, 3'd1, 1'b0, 3'd0},
    {1'b1, 3'd2, 1'b1, 3'd0},
    {1'b1, 3'd3, 1'b1, 3'd0},
    {1'b1, 3'd0, 1'b1, 3'd0}
  };

  initial begin
    #(8 * 150000);
    n_run++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    restart(0);
    chk(!tx_req && !pend_take && fail_count == 0, "R2 reset", tx_req, 0);

    foreach (VEC[i]) begin
      restart(int'(VEC[i][3]));
      rx(VEC[i][7] ? MINE : OTHER, VEC[i][6:4]);
      repeat (4) @(negedge clk);
      if (VEC[i][2:0] == 3'd0)
        chk(log_n == 0, VEC[i][7] ? "R2 idle ignore" : "R1 foreign query", log_n, 0);
      else
        chk(log_n == 1 && log_k[0] == VEC[i][2:0], "R3 reply kind", int'(log_k[0]), int'(VEC[i][2:0]));
    end

    // R3: after a no-data reply the block is idle and answers again
    restart(0);
    rx(MINE, 3'd1); wait_log(1);
    rx(MINE, 3'd1); wait_log(2);
    chk(log_n == 2 && log_k[1] == 3'd4, "R3 back to idle", int'(log_k[1]), 4);

    // R4 R5 R7: two frames, prompt acknowledgements
    restart(2);
    rx(MINE, 3'd1); wait_log(1);
    rx(MINE, 3'd2); wait_log(2);
    chk(log_k[1] == 3'd3, "R4 grant ack", int'(log_k[1]), 3);
    wait_log(3);
    chk(log_k[2] == 3'd6, "R5 first data", int'(log_k[2]), 6);
    repeat (3) @(negedge clk);
    chk(log_n == 3, "R5 waits for ack", log_n, 3);
    rx(MINE, 3'd3); wait_log(4);
    chk(log_k[3] == 3'd6 && pops == 1, "R5 ack pops", pops, 1);
    rx(MINE, 3'd3); wait_log(5);
    chk(log_k[4] == 3'd7 && pops == 2, "R7 end frame", int'(log_k[4]), 7);
    repeat (2) @(negedge clk);
    chk(!tx_req && fail_count == 0, "R7 idle after end", tx_req, 0);

    // R6 R1: silent recipient, foreign ack ignored
    restart(1);
    rx(MINE, 3'd1); wait_log(1);
    rx(MINE, 3'd2); wait_log(3);
    rx(OTHER, 3'd3);
    wait_log(6);
    chk(log_k[3] == 3'd6 && log_k[4] == 3'd6, "R1 R6 two retransmits", int'(log_k[4]), 6);
    chk(log_k[5] == 3'd7, "R6 moves on after third wait", int'(log_k[5]), 7);
    chk(fail_count == 1 && pops == 1, "R6 fail count", int'(fail_count), 1);

    // R4: grant wait expires, late grant ignored
    restart(1);
    rx(MINE, 3'd1); wait_log(1);
    repeat (12) @(negedge clk);
    rx(MINE, 3'd2);
    repeat (5) @(negedge clk);
    chk(log_n == 1, "R4 late grant ignored", log_n, 1);
    rx(MINE, 3'd1); wait_log(2);
    chk(log_k[1] == 3'd5, "R4 idle after wait", int'(log_k[1]), 5);

    // R8: grant window closes during the third frame
    restart(10);
    rx(MINE, 3'd1); wait_log(1);
    rx(MINE, 3'd2);
    repeat (120) @(negedge clk);
    begin
      int ends = 0;
      for (int i = 0; i < log_n; i++) if (log_k[i] == 3'd7) ends++;
      chk(ends == 0, "R8 no end frame", ends, 0);
    end
    chk(fail_count == 2 && pops == 2, "R8 frames abandoned", int'(fail_count), 2);
    chk(!tx_req, "R8 idle", tx_req, 0);

    // R9: stalled transmitter
    restart(0);
    tx_ready = 1'b0;
    rx(MINE, 3'd1);
    repeat (3) @(negedge clk);
    chk(tx_req && tx_kind == 3'd4, "R9 held", int'(tx_kind), 4);
    repeat (3) @(negedge clk);
    chk(tx_req && tx_kind == 3'd4 && log_n == 0, "R9 still held", int'(tx_kind), 4);
    tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(log_n == 1 && log_k[0] == 3'd4 && !tx_req, "R9 released", log_n, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule